// File: doc/BRIEF.md
# Multiply-Add Unit with Per-Operand Modifiers

This block evaluates one integer expression per accepted request: three 32-bit operands each pass through their own modifier, the first two modified values are multiplied, the third is added, and the sum passes through a fourth modifier and then an optional clamp. Every modifier has two steps. The first is a pre-step: pass, shift left, shift right, or pull out a bit field. The second is a sign step: keep, negate, absolute value, or negative absolute value.

The caller raises `in_valid` for one cycle with operands and control words. Exactly one cycle later, `out_valid` is high for one cycle. At that point `result` holds the final value and `prod_tap` holds the modified product, which is an internal node of the same expression. Both outputs keep their values until the next accepted request.

A two-state machine tracks the output register. ST_IDLE means no fresh result is shown. ST_SHOW means the result captured at the last edge is on the outputs. The transitions are:
- ST_IDLE to ST_SHOW on `in_valid`.
- ST_SHOW to ST_SHOW on `in_valid`.
- ST_SHOW to ST_IDLE without `in_valid`.
- ST_IDLE to ST_IDLE without `in_valid`.

Top module: `fx_fma`

## Requirements
- R1: `result` equals clamp(mo(ma(A)*mb(B) + mc(C))). The product is truncated to its low 32 bits and all addition wraps modulo 2^32.
- R2: The sign step uses code 0 for keep, 1 for negate (-x), 2 for absolute value and 3 for negative absolute value. Abs and nabs leave 0x80000000 unchanged.
- R3: The pre-step uses code 0 for pass and 1 for shift left by the amount field. Code 2 shifts right by the amount field, arithmetically when the signed flag is 1 and logically otherwise. Code 3 extracts bits [hi:lo], right-aligned and zero-extended, and gives 0 when hi < lo. The sign step acts on the pre-step's output.
- R4: Each 15-bit modifier word is laid out as [14:13] pre-step, [12:11] sign step, [10] signed flag, [9:5] amount or field low bit, [4:0] field high bit.
- R5: `clamp_mode` selects the clamp, and all comparisons are signed:
  - 0: none
  - 1: max with `bound_lo`
  - 2: max with raw operand C
  - 3: min with `bound_hi`
  - 4: min with raw operand C
  - 5: limit between `bound_lo` and `bound_hi`
  - 6 and 7: none
- R6: In limit mode, when `bound_lo` > `bound_hi` as signed values, the output equals `bound_lo`.
- R7: `prod_tap` equals ma(A)*mb(B), truncated to 32 bits, and is registered in the same cycle as `result`.
- R8: `out_valid` is high exactly in the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R9: Without `in_valid`, `result` and `prod_tap` hold their values.
- R10: During reset, `out_valid`, `result` and `prod_tap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_c | input | 32 | Operand C, also the second clamp value |
| mod_a | input | 15 | Modifier word for A |
| mod_b | input | 15 | Modifier word for B |
| mod_c | input | 15 | Modifier word for C |
| mod_out | input | 15 | Modifier word for the sum |
| clamp_mode | input | 3 | Clamp selection |
| bound_lo | input | 32 | Lower bound, max constant |
| bound_hi | input | 32 | Upper bound, min constant |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Final value |
| prod_tap | output | 32 | Modified product |

## Verification
The assertions assume that a request is taken only on a clock edge where `in_valid` is high. They also assume the bounds and clamp mode are stable only for that edge, so every bound check compares the new result against the bounds as they were at the request edge. The limit-ordering checks assume the caller may present the bounds in either order. The stimulus therefore drives inputs on the falling edge only, mixes directed cases with randomized operands, modifier words and bound orderings, and inserts idle gaps so that both hold behaviour and back-to-back requests occur.

// File: rtl/fx_pkg.sv
package fx_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned SH_W     = $clog2(DATA_W);
    localparam int unsigned XF_CFG_W = 2 + 2 + 1 + 2 * SH_W;
    localparam int unsigned N_OPND   = 3;

    typedef enum logic [1:0] {PRE_PASS, PRE_SHL, PRE_SHR, PRE_FIELD} pre_e;
    typedef enum logic [1:0] {SGN_KEEP, SGN_NEG, SGN_ABS, SGN_NABS} sgn_e;
    typedef enum logic [2:0] {
        CL_NONE, CL_MAXK, CL_MAXC, CL_MINK, CL_MINC, CL_LIMIT, CL_RSV6, CL_RSV7
    } clamp_e;
    typedef enum logic {ST_IDLE, ST_SHOW} state_e;

    typedef struct packed {
        pre_e            pre;
        sgn_e            sgn;
        logic            arith;
        logic [SH_W-1:0] lo;
        logic [SH_W-1:0] hi;
    } xf_cfg_t;
endpackage

// File: rtl/fx_xform.sv
module fx_xform
    import fx_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  xf_cfg_t           cfg,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] staged;
    logic [DATA_W-1:0] negated;
    logic [DATA_W-1:0] fmask;
    logic [SH_W-1:0]   span;

    // mask of (hi-lo+1) ones, valid only when hi >= lo
    assign span  = cfg.hi - cfg.lo;
    assign fmask = {DATA_W{1'b1}} >> (SH_W'(DATA_W - 1) - span);

    always_comb begin
        unique case (cfg.pre)
            PRE_PASS:  staged = din;
            PRE_SHL:   staged = din << cfg.lo;
            PRE_SHR:   staged = cfg.arith ? DATA_W'($signed(din) >>> cfg.lo)
                                          : din >> cfg.lo;
            PRE_FIELD: staged = (cfg.hi < cfg.lo) ? '0 : ((din >> cfg.lo) & fmask);
            default:   staged = din;
        endcase
    end

    assign negated = -staged;

    always_comb begin
        unique case (cfg.sgn)
            SGN_KEEP: dout = staged;
            SGN_NEG:  dout = negated;
            SGN_ABS:  dout = staged[DATA_W-1] ? negated : staged;
            SGN_NABS: dout = staged[DATA_W-1] ? staged : negated;
            default:  dout = staged;
        endcase
    end
endmodule

// File: rtl/fx_clamp.sv
module fx_clamp
    import fx_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-1:0] alt,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  clamp_e            mode,
    output logic [DATA_W-1:0] dout
);
    logic below_lo, above_hi, below_alt, above_alt, bounds_swapped;

    assign below_lo       = $signed(val) < $signed(lo);
    assign above_hi       = $signed(val) > $signed(hi);
    assign below_alt      = $signed(val) < $signed(alt);
    assign above_alt      = $signed(val) > $signed(alt);
    assign bounds_swapped = $signed(lo)  > $signed(hi);

    always_comb begin
        unique case (mode)
            CL_MAXK:  dout = below_lo  ? lo  : val;
            CL_MAXC:  dout = below_alt ? alt : val;
            CL_MINK:  dout = above_hi  ? hi  : val;
            CL_MINC:  dout = above_alt ? alt : val;
            CL_LIMIT: dout = (bounds_swapped || below_lo) ? lo : (above_hi ? hi : val);
            default:  dout = val;
        endcase
    end
endmodule

// File: rtl/fx_fma.sv
module fx_fma
    import fx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [DATA_W-1:0]   op_c,
    input  logic [XF_CFG_W-1:0] mod_a,
    input  logic [XF_CFG_W-1:0] mod_b,
    input  logic [XF_CFG_W-1:0] mod_c,
    input  logic [XF_CFG_W-1:0] mod_out,
    input  logic [2:0]          clamp_mode,
    input  logic [DATA_W-1:0]   bound_lo,
    input  logic [DATA_W-1:0]   bound_hi,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic [DATA_W-1:0]   prod_tap
);
    logic [DATA_W-1:0]   raw_op  [N_OPND];
    logic [XF_CFG_W-1:0] raw_cfg [N_OPND];
    logic [DATA_W-1:0]   xf_op   [N_OPND];
    logic [DATA_W-1:0]   product, sum, sum_xf, final_val;
    state_e              state, state_nx;

    assign raw_op[0]  = op_a;
    assign raw_op[1]  = op_b;
    assign raw_op[2]  = op_c;
    assign raw_cfg[0] = mod_a;
    assign raw_cfg[1] = mod_b;
    assign raw_cfg[2] = mod_c;

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        fx_xform u_xf (
            .din  (raw_op[i]),
            .cfg  (xf_cfg_t'(raw_cfg[i])),
            .dout (xf_op[i])
        );
    end

    assign product = xf_op[0] * xf_op[1];
    assign sum     = product + xf_op[2];

    fx_xform u_xf_out (
        .din  (sum),
        .cfg  (xf_cfg_t'(mod_out)),
        .dout (sum_xf)
    );

    fx_clamp u_clamp (
        .val  (sum_xf),
        .alt  (op_c),
        .lo   (bound_lo),
        .hi   (bound_hi),
        .mode (clamp_e'(clamp_mode)),
        .dout (final_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = in_valid ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            prod_tap <= '0;
        end else if (in_valid) begin
            result   <= final_val;
            prod_tap <= product;
        end
    end

    assign out_valid = (state == ST_SHOW);
endmodule

// File: rtl/fx_fma_chk.sv
module fx_fma_chk
    import fx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        clamp_mode,
    input logic [DATA_W-1:0] bound_lo,
    input logic [DATA_W-1:0] bound_hi,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] prod_tap
);
    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(prod_tap)));
    // R6
    limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_mode == 3'd5 && $signed(bound_lo) <= $signed(bound_hi))
        |=> ($signed(result) >= $signed($past(bound_lo)) &&
             $signed(result) <= $signed($past(bound_hi))));
    // R6
    limit_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_mode == 3'd5 && $signed(bound_lo) > $signed(bound_hi))
        |=> (result == $past(bound_lo)));
    // R5
    max_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_mode == 3'd1) |=> ($signed(result) >= $signed($past(bound_lo))));
    // R5
    min_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_mode == 3'd3) |=> ($signed(result) <= $signed($past(bound_hi))));
endmodule

bind fx_fma fx_fma_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .clamp_mode (clamp_mode),
    .bound_lo   (bound_lo),
    .bound_hi   (bound_hi),
    .out_valid  (out_valid),
    .result     (result),
    .prod_tap   (prod_tap)
);

// File: tb/fx_fma_test.sv
module fx_fma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic [14:0] mod_a = '0, mod_b = '0, mod_c = '0, mod_out = '0;
    logic [2:0]  clamp_mode = '0;
    logic [31:0] bound_lo = '0, bound_hi = '0;
    logic        out_valid;
    logic [31:0] result, prod_tap;

    int    checks = 0;
    int    errors = 0;
    bit    run_checks = 1'b0;
    string cur_req = "R1";

    logic        exp_valid = 1'b0;
    logic [31:0] exp_res = '0, exp_tap = '0;
    string       exp_req = "R10";

    always #10 clk = ~clk;

    fx_fma uut (.*);

    function automatic logic [14:0] mk(int pre, int sg, int ar, int lo, int hi);
        return {pre[1:0], sg[1:0], ar[0], lo[4:0], hi[4:0]};
    endfunction

    // behavioural modifier model
    function automatic logic [31:0] ref_mod(logic [31:0] x, logic [14:0] c);
        int lo = int'(c[9:5]);
        int hi = int'(c[4:0]);
        logic [31:0] v;
        logic [63:0] wide;
        case (c[14:13])
            2'd0: v = x;
            2'd1: v = x << lo;
            2'd2: begin
                v = x >> lo;
                if (c[10] && x[31]) v = v | ~(32'hFFFF_FFFF >> lo);
            end
            default: begin
                if (hi < lo) v = 32'd0;
                else begin
                    wide = ({32'd0, x} >> lo) & ((64'd1 << (hi - lo + 1)) - 64'd1);
                    v = wide[31:0];
                end
            end
        endcase
        case (c[12:11])
            2'd1: v = -v;
            2'd2: if (v[31]) v = -v;
            2'd3: if (!v[31]) v = -v;
            default: ;
        endcase
        return v;
    endfunction

    function automatic logic [31:0] ref_clamp(logic [31:0] r, logic [31:0] c,
                                              logic [31:0] lo, logic [31:0] hi, int m);
        int s  = $signed(r);
        int sc = $signed(c);
        int sl = $signed(lo);
        int sh = $signed(hi);
        case (m)
            1: return (s < sl) ? lo : r;
            2: return (s < sc) ? c : r;
            3: return (s > sh) ? hi : r;
            4: return (s > sc) ? c : r;
            5: begin
                if (sl > sh || s < sl) return lo;
                if (s > sh) return hi;
                return r;
            end
            default: return r;
        endcase
    endfunction

    // reference model, advanced on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_res   <= '0;
            exp_tap   <= '0;
            exp_req   <= "R10";
        end else if (in_valid) begin
            logic [63:0] p;
            logic [31:0] s;
            p = {32'd0, ref_mod(op_a, mod_a)} * {32'd0, ref_mod(op_b, mod_b)};
            s = p[31:0] + ref_mod(op_c, mod_c);
            exp_tap   <= p[31:0];
            exp_res   <= ref_clamp(ref_mod(s, mod_out), op_c, bound_lo, bound_hi,
                                   int'(clamp_mode));
            exp_valid <= 1'b1;
            exp_req   <= cur_req;
        end else begin
            exp_valid <= 1'b0;
            exp_req   <= "R9";
        end
    end

    always @(negedge clk) begin
        if (run_checks) begin
            checks++;
            if (out_valid !== exp_valid) begin
                errors++;
                $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
            end
            checks++;
            if (result !== exp_res) begin
                errors++;
                $display("FAIL %s result actual=%h expected=%h", exp_req, result, exp_res);
            end
            checks++;
            if (prod_tap !== exp_tap) begin
                errors++;
                $display("FAIL R7 (%s) prod_tap actual=%h expected=%h", exp_req, prod_tap, exp_tap);
            end
        end
    end

    task automatic send(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                        logic [14:0] ma, logic [14:0] mb, logic [14:0] mc, logic [14:0] mo,
                        int cm, logic [31:0] lo, logic [31:0] hi, string req);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c;
        mod_a = ma; mod_b = mb; mod_c = mc; mod_out = mo;
        clamp_mode = cm[2:0]; bound_lo = lo; bound_hi = hi;
        cur_req = req;
        in_valid = 1'b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = $urandom; op_b = $urandom; op_c = $urandom; // R9: changes ignored
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [14:0] id;
        id = mk(0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        // R10: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0 || prod_tap !== 32'd0) begin
            errors++;
            $display("FAIL R10 reset actual=%b/%h/%h expected=0/0/0", out_valid, result, prod_tap);
        end
        rst_n = 1'b1;
        run_checks = 1'b1;

        send(7, 6, 5, id, id, id, id, 0, 0, 0, "R1");
        send(32'h1_0001, 32'h1_0001, 32'hFFFF_FFFF, id, id, id, id, 0, 0, 0, "R1");
        send(3, 4, 0, mk(0,1,0,0,0), id, id, id, 0, 0, 0, "R2");
        send(32'hFFFF_FFF0, 1, 0, mk(0,2,0,0,0), id, id, id, 0, 0, 0, "R2");
        send(5, 1, 0, mk(0,3,0,0,0), id, id, id, 0, 0, 0, "R2");
        send(32'h8000_0000, 1, 0, mk(0,2,0,0,0), id, id, mk(0,3,0,0,0), 0, 0, 0, "R2");
        send(3, 1, 0, mk(1,0,0,4,0), id, id, id, 0, 0, 0, "R3");
        send(32'h8000_0100, 1, 0, mk(2,0,0,8,0), id, id, id, 0, 0, 0, "R3");
        send(32'h8000_0100, 1, 0, mk(2,0,1,8,0), id, id, id, 0, 0, 0, "R3");
        send(32'hABCD_1234, 1, 0, mk(3,0,0,8,15), id, id, id, 0, 0, 0, "R3");
        send(32'hABCD_1234, 1, 0, mk(3,0,0,0,31), id, id, id, 0, 0, 0, "R3");
        send(32'hABCD_1234, 1, 0, mk(3,0,0,9,3), id, id, id, 0, 0, 0, "R3");
        send(32'h0000_0F00, 1, 0, mk(3,1,0,8,11), id, id, id, 0, 0, 0, "R4");
        send(32'hFFFF_FF00, 1, 0, mk(2,2,1,4,0), id, id, id, 0, 0, 0, "R4");
        send(2, 3, 1, id, id, id, id, 1, 100, 0, "R5");
        send(2, 3, 1, id, id, id, id, 2, 0, 0, "R5");
        send(2, 3, 50, id, id, id, id, 2, 0, 0, "R5");
        send(2, 3, 1, id, id, id, id, 3, 0, 4, "R5");
        send(2, 3, -10, id, id, id, id, 4, 0, 0, "R5");
        send(2, 3, 1, id, id, id, id, 6, 0, 0, "R5");
        send(2, 3, 1, id, id, id, id, 5, -5, 5, "R6");
        send(-4, 3, 1, id, id, id, id, 5, -5, 5, "R6");
        send(2, 3, 1, id, id, id, id, 5, 20, 10, "R6");
        send(9, 9, 1, mk(0,1,0,0,0), id, id, id, 0, 0, 0, "R7");
        idle(3);
        send(1, 1, 1, id, id, id, id, 0, 0, 0, "R8");
        idle(1);
        send(2, 2, 2, id, id, id, id, 0, 0, 0, "R8");
        for (int n = 0; n < 400; n++) begin
            send($urandom, $urandom, $urandom, 15'($urandom), 15'($urandom),
                 15'($urandom), 15'($urandom), int'($urandom_range(0, 7)),
                 $urandom, $urandom, "R1");
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(2);
        run_checks = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule